// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns a decoded operand-address byte, up to two displacement bytes, the four base and index register values and the four segment register values into a 20-bit physical memory address. For memory operands it adds a base, an index and a displacement into a 16-bit offset that wraps at 64K. It then picks a segment, either from the default rules or from a decoded override. The physical address is that segment shifted left by four bits plus the offset. It also handles three implicit kinds of access: stack-pointer accesses, instruction fetches and string destinations.

A request is presented for one cycle with `req_valid`. The result appears on the registered outputs in the next cycle, flagged by `out_valid`. When the operand-address byte names a register rather than memory, the block raises `is_reg` and returns zero for the address fields. Fetching the displacement bytes and running the bus cycle are left to the surrounding logic.

Top module: `ea_gen`

## Requirements
- R1: For every memory access, `phys_addr` = ((segment value << 4) + offset), truncated to 20 bits, so that FFFF0h + 20h gives 00010h. For example, segment 12A4h with offset 0022h gives 12A62h.
- R2: For operand accesses (`acc_kind` = 00), the low three bits of `modrm` (bits 2:0) pick the offset terms: 000 base_b+idx_s, 001 base_b+idx_d, 010 base_p+idx_s, 011 base_p+idx_d, 100 idx_s, 101 idx_d, 110 base_p, 111 base_b. The sum is taken modulo 2^16.
- R3: The top two bits of `modrm` (bits 7:6) select the displacement: 00 adds none, 01 adds `disp_lo` sign-extended to 16 bits, and 10 adds {`disp_hi`,`disp_lo`}.
- R4: When mode is 00 and r/m is 110, the offset is {`disp_hi`,`disp_lo`} alone and the default segment is the data segment.
- R5: Without an override, an operand access that uses `base_p` (r/m 010, 011, or 110 with mode 01 or 10) uses the stack segment. All other operand accesses use the data segment.
- R6: For an operand access with `ovr_valid`=1, `ovr_sel` picks the segment: 00 extra, 01 code, 10 stack, 11 data. `seg_used` reports the chosen segment in the same code.
- R7: Mode 11 on an operand access sets `is_reg`=1 and drives `phys_addr`, `eff_offset` and `seg_used` to zero.
- R8: A stack access (`acc_kind`=10) uses `sp_val` as the offset and the stack segment, and ignores any override.
- R9: An instruction fetch (`acc_kind`=11) uses `ip_val` as the offset and the code segment, and ignores any override.
- R10: A string destination (`acc_kind`=01) uses `idx_d` as the offset and the extra segment, and ignores any override.
- R11: `out_valid` is `req_valid` delayed by one cycle. After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe |
| acc_kind | input | 2 | 00 operand, 01 string destination, 10 stack, 11 fetch |
| modrm | input | 8 | Operand-address byte: mode[7:6], aux[5:3], r/m[2:0] |
| disp_lo | input | 8 | Displacement low byte |
| disp_hi | input | 8 | Displacement high byte |
| base_b | input | 16 | General base register |
| base_p | input | 16 | Frame base register |
| idx_s | input | 16 | Source index register |
| idx_d | input | 16 | Destination index register |
| sp_val | input | 16 | Stack pointer |
| ip_val | input | 16 | Instruction pointer |
| seg_x | input | 16 | Extra segment |
| seg_c | input | 16 | Code segment |
| seg_s | input | 16 | Stack segment |
| seg_d | input | 16 | Data segment |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| out_valid | output | 1 | Result valid |
| phys_addr | output | 20 | Physical address |
| eff_offset | output | 16 | 16-bit offset |
| seg_used | output | 2 | Segment code applied |
| is_reg | output | 1 | Operand is a register |

## Verification
The assertions check on every cycle the one-cycle valid timing and the fixed segments of stack, fetch and string-destination accesses, whatever override is presented. They also check that an override steers memory operands and that register operands come out as zeros. A further assertion checks that the low nibble of the address always equals the low nibble of the offset. Only the bench scenarios show the arithmetic itself: the r/m term table, sign extension of short displacements, the 16-bit and 20-bit wraparounds, direct addressing, and the frame-base default to the stack segment.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int OFS_W = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W = OFS_W + SEG_SHIFT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       acc_kind,
  input  logic [7:0]       modrm,
  input  logic [7:0]       disp_lo,
  input  logic [7:0]       disp_hi,
  input  logic [OFS_W-1:0] base_b,
  input  logic [OFS_W-1:0] base_p,
  input  logic [OFS_W-1:0] idx_s,
  input  logic [OFS_W-1:0] idx_d,
  input  logic [OFS_W-1:0] sp_val,
  input  logic [OFS_W-1:0] ip_val,
  input  logic [OFS_W-1:0] seg_x,
  input  logic [OFS_W-1:0] seg_c,
  input  logic [OFS_W-1:0] seg_s,
  input  logic [OFS_W-1:0] seg_d,
  input  logic             ovr_valid,
  input  logic [1:0]       ovr_sel,
  output logic             out_valid,
  output logic [PA_W-1:0]  phys_addr,
  output logic [OFS_W-1:0] eff_offset,
  output logic [1:0]       seg_used,
  output logic             is_reg
);
  localparam logic [1:0] K_OPND = 2'b00, K_STRD = 2'b01, K_STACK = 2'b10, K_FETCH = 2'b11;
  localparam logic [1:0] S_X = 2'b00, S_C = 2'b01, S_S = 2'b10, S_D = 2'b11;

  wire [1:0] mode = modrm[7:6];
  wire [2:0] rm   = modrm[2:0];
  wire direct  = (mode == 2'b00) && (rm == 3'b110);
  wire reg_op  = (acc_kind == K_OPND) && (mode == 2'b11);
  wire bp_used = (rm == 3'b010) || (rm == 3'b011) || ((rm == 3'b110) && !direct);

  logic [OFS_W-1:0] disp, base, index, opnd_ofs, off_n, seg_val;
  logic [1:0] seg_n;

  always_comb begin
    if (mode == 2'b01)
      disp = OFS_W'($signed(disp_lo));
    else if (mode == 2'b10 || direct)
      disp = OFS_W'({disp_hi, disp_lo});
    else
      disp = '0;

    case (rm)
      3'b000, 3'b001, 3'b111: base = base_b;
      3'b010, 3'b011:         base = base_p;
      3'b110:                 base = direct ? '0 : base_p;
      default:                base = '0;
    endcase

    case (rm)
      3'b000, 3'b010, 3'b100: index = idx_s;
      3'b001, 3'b011, 3'b101: index = idx_d;
      default:                index = '0;
    endcase
  end

  assign opnd_ofs = base + index + disp;

  always_comb begin
    case (acc_kind)
      K_STRD:  begin off_n = idx_d;  seg_n = S_X; end
      K_STACK: begin off_n = sp_val; seg_n = S_S; end
      K_FETCH: begin off_n = ip_val; seg_n = S_C; end
      default: begin
        off_n = opnd_ofs;
        seg_n = ovr_valid ? ovr_sel : (bp_used ? S_S : S_D);
      end
    endcase
    case (seg_n)
      S_X:     seg_val = seg_x;
      S_C:     seg_val = seg_c;
      S_S:     seg_val = seg_s;
      default: seg_val = seg_d;
    endcase
  end

  wire [PA_W-1:0] pa_n = (PA_W'(seg_val) << SEG_SHIFT) + PA_W'(off_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      phys_addr  <= '0;
      eff_offset <= '0;
      seg_used   <= '0;
      is_reg     <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        is_reg     <= reg_op;
        phys_addr  <= reg_op ? '0 : pa_n;
        eff_offset <= reg_op ? '0 : off_n;
        seg_used   <= reg_op ? '0 : seg_n;
      end
    end
  end

  a_r11_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(req_valid));
  a_r8_stack_seg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(acc_kind) == K_STACK |-> seg_used == S_S && !is_reg);
  a_r9_fetch_seg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(acc_kind) == K_FETCH |-> seg_used == S_C && !is_reg);
  a_r10_strdst_seg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(acc_kind) == K_STRD |-> seg_used == S_X && !is_reg);
  a_r6_override: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(acc_kind) == K_OPND && $past(ovr_valid) && $past(modrm[7:6]) != 2'b11
    |-> seg_used == $past(ovr_sel));
  a_r7_reg_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && is_reg |-> phys_addr == '0 && eff_offset == '0 && seg_used == '0);
  a_r1_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !is_reg |-> phys_addr[SEG_SHIFT-1:0] == eff_offset[SEG_SHIFT-1:0]);
endmodule

// File: tb/ea_gen_bench.sv
module ea_gen_bench;
  logic clk = 0, rst_n = 0, req_valid = 0, ovr_valid = 0;
  logic [1:0] acc_kind = 0, ovr_sel = 0;
  logic [7:0] modrm = 0, disp_lo = 0, disp_hi = 0;
  logic [15:0] base_b = 0, base_p = 0, idx_s = 0, idx_d = 0, sp_val = 0, ip_val = 0;
  logic [15:0] seg_x = 0, seg_c = 0, seg_s = 0, seg_d = 0;
  logic out_valid, is_reg;
  logic [19:0] phys_addr;
  logic [15:0] eff_offset;
  logic [1:0] seg_used;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [38:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  ea_gen u_ea_gen (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_kind(acc_kind),
    .modrm(modrm), .disp_lo(disp_lo), .disp_hi(disp_hi), .base_b(base_b), .base_p(base_p),
    .idx_s(idx_s), .idx_d(idx_d), .sp_val(sp_val), .ip_val(ip_val), .seg_x(seg_x),
    .seg_c(seg_c), .seg_s(seg_s), .seg_d(seg_d), .ovr_valid(ovr_valid), .ovr_sel(ovr_sel),
    .out_valid(out_valid), .phys_addr(phys_addr), .eff_offset(eff_offset),
    .seg_used(seg_used), .is_reg(is_reg));

  function automatic logic [38:0] model(input logic [1:0] k, input logic [7:0] m,
                                         input logic ov, input logic [1:0] os);
    logic [15:0] off, sv, d;
    logic [1:0] sc;
    logic [2:0] r;
    r = m[2:0];
    if (k == 2'b00 && m[7:6] == 2'b11) return '0 | (39'd1 << 38);
    if (k == 2'b10) begin off = sp_val; sc = 2'b10; end
    else if (k == 2'b11) begin off = ip_val; sc = 2'b01; end
    else if (k == 2'b01) begin off = idx_d; sc = 2'b00; end
    else if (m[7:6] == 2'b00 && r == 3'b110) begin off = {disp_hi, disp_lo}; sc = 2'b11; end
    else begin
      d = (m[7:6] == 2'b01) ? {{8{disp_lo[7]}}, disp_lo} : (m[7:6] == 2'b10) ? {disp_hi, disp_lo} : 16'h0;
      off = d;
      if (r == 0 || r == 1 || r == 7) off += base_b;
      if (r == 2 || r == 3 || r == 6) off += base_p;
      if (r == 0 || r == 2 || r == 4) off += idx_s;
      if (r == 1 || r == 3 || r == 5) off += idx_d;
      sc = (r == 2 || r == 3 || r == 6) ? 2'b10 : 2'b11;
      if (ov) sc = os;
    end
    sv = (sc == 0) ? seg_x : (sc == 1) ? seg_c : (sc == 2) ? seg_s : seg_d;
    return {1'b0, sc, off, 20'({sv, 4'h0} + {4'h0, off})};
  endfunction

  task automatic issue(input logic [1:0] k, input logic [7:0] m, input logic [7:0] lo,
                       input logic [7:0] hi, input logic ov, input logic [1:0] os, input string tag);
    @(negedge clk);
    acc_kind = k; modrm = m; disp_lo = lo; disp_hi = hi; ovr_valid = ov; ovr_sel = os;
    req_valid = 1;
    exp_q.push_back(model(k, m, ov, os));
    tag_q.push_back(tag);
  endtask

  task automatic expect_val(input bit ok, input string tag, input logic [38:0] act, input logic [38:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) expect_val(0, "R11 unexpected out_valid", 39'd1, 39'd0);
      else begin
        logic [38:0] e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {is_reg, seg_used, eff_offset, phys_addr};
        expect_val(a == e, t, a, e);
      end
    end
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    expect_val(out_valid == 0 && phys_addr == 0 && eff_offset == 0 && is_reg == 0,
               "R11 reset state", {is_reg, seg_used, eff_offset, phys_addr}, 39'd0);
    rst_n = 1;
    seg_x = 16'h2000; seg_c = 16'hF000; seg_s = 16'h3000; seg_d = 16'h12A4;
    base_b = 16'h0100; base_p = 16'h0200; idx_s = 16'h0010; idx_d = 16'h0020;
    sp_val = 16'hFFFE; ip_val = 16'h0123;
    issue(0, 8'b00_000_110, 8'h22, 8'h00, 0, 0, "R1 R4 direct 12A4:0022");
    for (int r = 0; r < 8; r++) issue(0, {2'b00, 3'b000, 3'(r)}, 8'h00, 8'h00, 0, 0, "R2 R5 mode00 r/m");
    for (int r = 0; r < 8; r++) issue(0, {2'b01, 3'b101, 3'(r)}, 8'h80, 8'h00, 0, 0, "R3 R5 mode01 negative disp");
    issue(0, 8'b01_000_111, 8'h7F, 8'hAA, 0, 0, "R3 mode01 positive disp");
    issue(0, 8'b10_000_011, 8'h34, 8'h12, 0, 0, "R3 mode10 16-bit disp");
    issue(0, 8'b10_000_110, 8'hFF, 8'hFF, 0, 0, "R5 base_p mode10 stack seg");
    for (int s = 0; s < 4; s++) issue(0, 8'b01_000_010, 8'h04, 8'h00, 1, 2'(s), "R6 override");
    issue(0, 8'b11_000_001, 8'h00, 8'h00, 0, 0, "R7 register operand");
    issue(0, 8'b11_010_110, 8'h00, 8'h00, 1, 2'b00, "R7 register operand override");
    issue(2, 8'h00, 8'h00, 8'h00, 1, 2'b11, "R8 stack ignores override");
    issue(3, 8'b11_000_000, 8'h00, 8'h00, 1, 2'b00, "R9 fetch ignores override");
    issue(1, 8'b00_000_110, 8'h00, 8'h00, 1, 2'b11, "R10 string dest ignores override");
    @(negedge clk); req_valid = 0;
    @(negedge clk);
    @(negedge clk);
    expect_val(out_valid == 0, "R11 idle after request", {38'd0, out_valid}, 39'd0);
    base_b = 16'hFFFF; idx_s = 16'h0002; seg_d = 16'hFFFF;
    issue(0, 8'b00_000_000, 8'h00, 8'h00, 0, 0, "R2 offset wrap");
    issue(0, 8'b00_000_110, 8'h20, 8'h00, 0, 0, "R1 physical wrap");
    @(negedge clk); req_valid = 0;
    repeat (3) @(negedge clk);
    expect_val(exp_q.size() == 0, "R11 all results returned", 39'(exp_q.size()), 39'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule